// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is a single binary down-counter channel with one output line whose waveform depends on an operating mode chosen when a count is written. A host-side register block supplies a count value, a 3-bit mode code and a one-cycle write strobe. The block turns these into one of six behaviours:

- an interrupt-style level on terminal count
- a retriggerable one-shot
- a divide-by-N rate generator
- a square-wave generator
- a strobe started by the count write
- a strobe started by a gate rising edge

Every rising edge of `clk` is one counter clock.

The `gate` input is registered once on `clk` so that its rising edges can be detected. Depending on the mode, `gate` acts as a count enable, as a trigger, or as both. The live count is always visible on `count_live`, so a host block can latch it. Counting is binary only. A written count of zero stands for 2^CNT_W.

Top module: `tmr_channel`

## Requirements
- R1: After reset `tmr_out` is 1 and `count_live` is 0, and both stay so until the first cycle with `count_wr` high.
- R2: Mode code 0 (level on terminal count). The write clock edge loads N and drives `tmr_out` low. Each later clock with `gate` high decrements the count, and clocks with `gate` low hold it. The clock that takes the count from 1 to 0 sets `tmr_out` high. From then on the output stays high and the count stays at 0 until the next write.
- R3: Mode code 1 (one-shot). A write only stores N and leaves `tmr_out` high. The clock that sees a `gate` rising edge loads N and drives `tmr_out` low. The count then decrements every clock whatever the level of `gate`, and `tmr_out` returns high on the clock that reaches 0. A rising edge before that reloads N and keeps `tmr_out` low, so the output is low for N clocks after the last edge.
- R4: Mode code 2 (rate generator, N >= 2). With `gate` high the write loads N. After k clocks the count is N - (k mod N), and `tmr_out` is low exactly when k mod N = N-1. This gives one low clock in every N.
- R5: Mode code 3 (square wave, N >= 2). With `gate` high, `tmr_out` is high for (N+1)/2 clocks and then low for N/2 clocks (integer division), and this repeats. The count starts each high half at N rounded up to even and each low half at N rounded down to even, and it drops by 2 per clock.
- R6: In modes 2 and 3, a clock with `gate` low forces `tmr_out` high and holds the count. The clock that sees the next `gate` rising edge restarts the period from N, with `tmr_out` high.
- R7: Mode code 4 (write-started strobe). The write loads N and keeps `tmr_out` high. Clocks with `gate` high decrement the count. On the clock that reaches 0, `tmr_out` goes low for exactly one clock. The count then stays at 0 and the output stays high until the next write.
- R8: Mode code 5 (gate-started strobe). A write only stores N. A `gate` rising edge loads N. The count then decrements every clock, and `tmr_out` goes low for one clock when it reaches 0. A rising edge during the countdown reloads N.
- R9: A written count of 0 is taken as 65536. In mode 0 `count_live` reads 0 right after the write and 16'hFFFF one clock later, with `tmr_out` still low.
- R10: The mode is captured on the write clock edge, and later changes of `mode_sel` have no effect until the next write. Mode codes 6 and 7 behave as codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; every rising edge is one count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode code, captured with the count write |
| count_in | input | 16 | Count value N (0 means 65536) |
| count_wr | input | 1 | One-cycle strobe: a count has been written |
| gate | input | 1 | Gate/trigger input, registered on clk for edge detection |
| tmr_out | output | 1 | Channel output waveform |
| count_live | output | 16 | Current count, for latching by the host block |

## Verification
A wrong count register shows on `count_live` in the clock after the fault. It reaches `tmr_out` no later than the next terminal count, so every sweep checks the count and the output on every clock of several full periods.

A wrong half-period reload in the square wave moves the output edge within one half-period. A lost retrigger or an ignored gate level shows as an output transition that arrives early or never arrives. The bench sweeps N for every mode and predicts each cycle from modulo arithmetic on the clock index.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TC      = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTRB  = 3'd4,
    M_HWSTRB  = 3'd5
  } tmr_mode_e;

  // Codes 6 and 7 alias the two periodic modes.
  function automatic tmr_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd6:    decode_mode = M_RATE;
      3'd7:    decode_mode = M_SQUARE;
      default: decode_mode = tmr_mode_e'(code);
    endcase
  endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic [2:0]       mode_code,
  input  logic [CNT_W-1:0] load_val,
  input  logic             gate,
  input  logic             gate_rise,
  output logic [CNT_W-1:0] count,
  output logic             out
);

  localparam int EW = CNT_W + 1;
  localparam logic [EW-1:0] ONE = EW'(1);
  localparam logic [EW-1:0] TWO = EW'(2);

  // Effective count: zero stands for 2^CNT_W.
  function automatic logic [EW-1:0] eff_of(input logic [CNT_W-1:0] v);
    eff_of = (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  // Square wave half loads: high half rounds up to even, low half down.
  function automatic logic [EW-1:0] sq_hi(input logic [EW-1:0] e);
    sq_hi = e + {{(EW-1){1'b0}}, e[0]};
  endfunction

  function automatic logic [EW-1:0] sq_lo(input logic [EW-1:0] e);
    sq_lo = e - {{(EW-1){1'b0}}, e[0]};
  endfunction

  tmr_mode_e     mode_q;
  tmr_mode_e     mode_n;
  logic [EW-1:0] init_q;
  logic [EW-1:0] cnt;
  logic [EW-1:0] new_eff;
  logic          armed;
  logic          busy;
  logic          out_q;
  logic          phase_hi;
  logic          at_one;
  logic          at_two;
  logic          trig;

  assign mode_n  = decode_mode(mode_code);
  assign new_eff = eff_of(load_val);
  assign at_one  = (cnt == ONE);
  assign at_two  = (cnt == TWO);
  assign trig    = armed & gate_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_TC;
      init_q   <= '0;
      cnt      <= '0;
      armed    <= 1'b0;
      busy     <= 1'b0;
      out_q    <= 1'b1;
      phase_hi <= 1'b1;
    end else if (load_stb) begin
      mode_q   <= mode_n;
      init_q   <= new_eff;
      armed    <= 1'b1;
      phase_hi <= 1'b1;
      case (mode_n)
        M_TC: begin
          cnt   <= new_eff;
          busy  <= 1'b1;
          out_q <= 1'b0;
        end
        M_SQUARE: begin
          cnt   <= sq_hi(new_eff);
          busy  <= 1'b1;
          out_q <= 1'b1;
        end
        M_RATE, M_SWSTRB: begin
          cnt   <= new_eff;
          busy  <= 1'b1;
          out_q <= 1'b1;
        end
        default: begin
          busy  <= 1'b0;
          out_q <= 1'b1;
        end
      endcase
    end else begin
      case (mode_q)
        M_TC: begin
          if (busy && gate) begin
            cnt <= cnt - ONE;
            if (at_one) begin
              out_q <= 1'b1;
              busy  <= 1'b0;
            end
          end
        end
        M_ONESHOT: begin
          if (trig) begin
            cnt   <= init_q;
            out_q <= 1'b0;
            busy  <= 1'b1;
          end else if (busy) begin
            cnt <= cnt - ONE;
            if (at_one) begin
              out_q <= 1'b1;
              busy  <= 1'b0;
            end
          end
        end
        M_RATE: begin
          if (!gate) begin
            out_q <= 1'b1;
          end else if (trig) begin
            cnt   <= init_q;
            out_q <= 1'b1;
            busy  <= 1'b1;
          end else if (busy) begin
            cnt   <= at_one ? init_q : cnt - ONE;
            out_q <= ~at_two;
          end
        end
        M_SQUARE: begin
          if (!gate) begin
            out_q <= 1'b1;
          end else if (trig) begin
            cnt      <= sq_hi(init_q);
            phase_hi <= 1'b1;
            out_q    <= 1'b1;
            busy     <= 1'b1;
          end else if (busy) begin
            if (at_two) begin
              phase_hi <= ~phase_hi;
              out_q    <= ~phase_hi;
              cnt      <= phase_hi ? sq_lo(init_q) : sq_hi(init_q);
            end else begin
              cnt <= cnt - TWO;
            end
          end
        end
        M_SWSTRB: begin
          if (!out_q) out_q <= 1'b1;
          if (busy && gate) begin
            cnt <= cnt - ONE;
            if (at_one) begin
              out_q <= 1'b0;
              busy  <= 1'b0;
            end
          end
        end
        M_HWSTRB: begin
          if (!out_q) out_q <= 1'b1;
          if (trig) begin
            cnt  <= init_q;
            busy <= 1'b1;
          end else if (busy) begin
            cnt <= cnt - ONE;
            if (at_one) begin
              out_q <= 1'b0;
              busy  <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign count = cnt[CNT_W-1:0];
  assign out   = out_q;

  // R1
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (out_q && cnt == '0));

  // R2
  tc_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && mode_n == M_TC) |=> !out_q);

  // R4
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q && !load_stb) |=> out_q);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == M_TC || mode_q == M_RATE || mode_q == M_SWSTRB))
      |-> (cnt != '0 && cnt <= init_q));

  // R5
  sq_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && busy) |-> !cnt[0]);

  // R6
  gate_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate && !load_stb) |=> out_q);

  // R7
  strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTRB || mode_q == M_HWSTRB) && !out_q && !load_stb) |=> out_q);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic [CNT_W-1:0] count_in,
  input  logic             count_wr,
  input  logic             gate,
  output logic             tmr_out,
  output logic [CNT_W-1:0] count_live
);

  logic gate_rise;

  tmr_gate_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (count_wr),
    .mode_code (mode_sel),
    .load_val  (count_in),
    .gate      (gate),
    .gate_rise (gate_rise),
    .count     (count_live),
    .out       (tmr_out)
  );

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode_sel;
  logic [15:0] count_in;
  logic        count_wr;
  logic        gate;
  logic        tmr_out;
  logic [15:0] count_live;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tmr_channel dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .count_in   (count_in),
    .count_wr   (count_wr),
    .gate       (gate),
    .tmr_out    (tmr_out),
    .count_live (count_live)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    count_wr = 1'b1;
    mode_sel = m;
    count_in = v;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; count_wr = 1'b0; gate = 1'b0; mode_sel = 3'd0; count_in = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state and idle
    check("R1 out", tmr_out, 1);
    check("R1 count", count_live, 0);
    gate = 1'b1;
    repeat (3) tick();
    check("R1 idle out", tmr_out, 1);
    check("R1 idle count", count_live, 0);

    // R2 mode 0 sweep
    for (int n = 1; n <= 6; n++) begin
      do_load(3'd0, 16'(n));
      check("R2 load out", tmr_out, 0);
      check("R2 load count", count_live, n);
      for (int k = 1; k <= n + 2; k++) begin
        tick();
        check("R2 out", tmr_out, (k >= n) ? 1 : 0);
        check("R2 count", count_live, (k >= n) ? 0 : n - k);
      end
    end
    // R2 gate low pauses
    gate = 1'b0;
    do_load(3'd0, 16'd5);
    repeat (3) tick();
    check("R2 pause count", count_live, 5);
    check("R2 pause out", tmr_out, 0);
    gate = 1'b1;
    tick();
    check("R2 resume count", count_live, 4);
    // R9 zero means 65536
    do_load(3'd0, 16'd0);
    check("R9 count", count_live, 0);
    check("R9 out", tmr_out, 0);
    tick();
    check("R9 wrap count", count_live, 16'hFFFF);
    check("R9 wrap out", tmr_out, 0);

    // R3 one-shot sweep
    for (int n = 1; n <= 5; n++) begin
      gate = 1'b0;
      do_load(3'd1, 16'(n));
      tick();
      check("R3 armed out", tmr_out, 1);
      gate = 1'b1;
      tick();
      check("R3 trig out", tmr_out, 0);
      check("R3 trig count", count_live, n);
      for (int k = 1; k <= n + 1; k++) begin
        tick();
        check("R3 out", tmr_out, (k >= n) ? 1 : 0);
      end
    end
    // R3 retrigger
    gate = 1'b0;
    do_load(3'd1, 16'd5);
    tick();
    gate = 1'b1;
    tick();
    gate = 1'b0;
    tick();
    check("R3 retrig pre count", count_live, 4);
    gate = 1'b1;
    tick();
    check("R3 retrig count", count_live, 5);
    check("R3 retrig out", tmr_out, 0);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R3 retrig out", tmr_out, (k >= 5) ? 1 : 0);
    end

    // R4 rate generator sweep
    gate = 1'b1;
    tick();
    for (int n = 2; n <= 6; n++) begin
      do_load(3'd2, 16'(n));
      for (int k = 0; k <= 3 * n; k++) begin
        if (k > 0) tick();
        check("R4 count", count_live, n - (k % n));
        check("R4 out", tmr_out, ((k % n) == n - 1) ? 0 : 1);
      end
    end
    // R6 gate low in mode 2
    do_load(3'd2, 16'd4);
    tick(); tick();
    gate = 1'b0;
    tick();
    check("R6 rate out", tmr_out, 1);
    check("R6 rate hold", count_live, 2);
    tick(); tick();
    check("R6 rate hold2", count_live, 2);
    gate = 1'b1;
    tick();
    check("R6 rate reload", count_live, 4);
    check("R6 rate reload out", tmr_out, 1);
    tick(); tick(); tick();
    check("R6 rate pulse", tmr_out, 0);

    // R5 square wave sweep
    for (int n = 2; n <= 7; n++) begin
      int hi, h2, lo;
      hi = (n + 1) / 2;
      h2 = n + (n % 2);
      lo = n - (n % 2);
      do_load(3'd3, 16'(n));
      for (int k = 0; k <= 3 * n; k++) begin
        int p;
        if (k > 0) tick();
        p = k % n;
        check("R5 out", tmr_out, (p < hi) ? 1 : 0);
        check("R5 count", count_live, (p < hi) ? h2 - 2 * p : lo - 2 * (p - hi));
      end
    end
    // R6 gate low in mode 3
    do_load(3'd3, 16'd6);
    tick(); tick(); tick();
    check("R6 sq low phase", tmr_out, 0);
    gate = 1'b0;
    tick();
    check("R6 sq forced high", tmr_out, 1);
    gate = 1'b1;
    tick();
    check("R6 sq reload", count_live, 6);

    // R7 write-started strobe sweep
    for (int n = 1; n <= 5; n++) begin
      do_load(3'd4, 16'(n));
      check("R7 load out", tmr_out, 1);
      check("R7 load count", count_live, n);
      for (int k = 1; k <= n + 3; k++) begin
        tick();
        check("R7 out", tmr_out, (k == n) ? 0 : 1);
        check("R7 count", count_live, (k >= n) ? 0 : n - k);
      end
    end
    gate = 1'b0;
    do_load(3'd4, 16'd3);
    tick(); tick();
    check("R7 pause count", count_live, 3);
    gate = 1'b1;

    // R8 gate-started strobe sweep
    for (int n = 1; n <= 4; n++) begin
      gate = 1'b0;
      do_load(3'd5, 16'(n));
      tick();
      gate = 1'b1;
      tick();
      check("R8 trig count", count_live, n);
      check("R8 trig out", tmr_out, 1);
      for (int k = 1; k <= n + 2; k++) begin
        tick();
        check("R8 out", tmr_out, (k == n) ? 0 : 1);
      end
    end
    // R8 retrigger
    gate = 1'b0;
    do_load(3'd5, 16'd4);
    tick();
    gate = 1'b1;
    tick(); tick();
    gate = 1'b0;
    tick();
    gate = 1'b1;
    tick();
    check("R8 retrig count", count_live, 4);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R8 retrig out", tmr_out, (k == 4) ? 0 : 1);
    end

    // R10 aliases and mode capture
    gate = 1'b1;
    do_load(3'd6, 16'd3);
    mode_sel = 3'd0;
    for (int k = 0; k <= 6; k++) begin
      if (k > 0) tick();
      check("R10 alias6 out", tmr_out, ((k % 3) == 2) ? 0 : 1);
      check("R10 alias6 count", count_live, 3 - (k % 3));
    end
    do_load(3'd7, 16'd4);
    mode_sel = 3'd4;
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) tick();
      check("R10 alias7 out", tmr_out, ((k % 4) < 2) ? 1 : 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule